// File: doc/BRIEF.md
# Supply Reset Delay Generator

This block produces the active-low reset that a processor sees when its supply sags or its watchdog gives up. It takes an already-thresholded undervoltage level and a watchdog-fault request. From these it generates one reset line that stays low long enough for the processor to start cleanly. The block runs on a fast clock and counts delay time in units of a slow tick enable, so one design serves both real millisecond timing and short simulation timing.

An undervoltage level must persist for a reaction time, counted in clock cycles, before it counts. Shorter dips are filtered out. A confirmed undervoltage holds reset low for as long as it lasts. A single-cycle watchdog fault is stretched into a full delay. After any cause clears, reset stays low for a delay of a fast or a slow length, chosen by two static mode inputs. Reset is then released, and a one-cycle strobe marks the release so that a watchdog can open its first ignore window.

Top module: `supply_rst_gen`

## Requirements
- R1: Once an undervoltage is confirmed, `resetN` is low from the next clock and stays low for as long as `underVolt` remains high, whatever the tick input does.
- R2: After a confirmed undervoltage clears, `resetN` stays low until the selected number of tick enables has been counted in the delay phase, and rises on the clock that takes the last tick.
- R3: With `modeSel1`=0 and `modeSel0`=0 the delay is `FAST_TICKS` ticks.
- R4: With any other mode code (01, 10, 11) the delay is `SLOW_TICKS` ticks.
- R5: `underVolt` that is high for fewer than `REACT_CYCLES` consecutive clocks has no effect on `resetN`, even when such dips repeat with a single low cycle between them. `underVolt` that is high for `REACT_CYCLES` consecutive clocks drives `resetN` low after the following clock edge.
- R6: A `wdFault` pulse of one clock drives `resetN` low from the next clock and holds it low for a full delay.
- R7: `releasePulse` is high for exactly one clock, on the same clock where `resetN` goes from low to high, and is low at all other times.
- R8: A watchdog fault or a confirmed undervoltage that arrives while a delay is running restarts the delay from zero.
- R9: While `enable` is low or `rstSync` is high, `resetN` is low, ticks have no effect, and all counters are cleared, so a full delay follows when both are released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstSync | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Block enable; low forces reset and clears state |
| tickEn | input | 1 | Single-cycle time-base tick for delay counting |
| underVolt | input | 1 | Thresholded undervoltage level, high = supply low |
| wdFault | input | 1 | Watchdog fault request, one clock or longer |
| modeSel0 | input | 1 | Mode select bit 0 |
| modeSel1 | input | 1 | Mode select bit 1 |
| resetN | output | 1 | Reset output, active low |
| releasePulse | output | 1 | One-clock strobe on the rising edge of resetN |

## Verification
A delay counter that is not cleared on restart shows as `resetN` rising too early. The error appears a whole number of ticks before the expected release, so the bench counts ticks one at a time and samples just before and just after the last one. A reaction filter that counts off by one shows within `REACT_CYCLES`+1 clocks of a dip starting: the output either drops on a dip one cycle too short or stays high one cycle too long. A wrong state after a fault or a disable shows on the next clock as `resetN` still high. A misplaced release strobe shows on the same clock as the edge it should mark.

// File: rtl/supply_rst_pkg.sv
package supply_rst_pkg;

  typedef enum logic [1:0] {
    ST_HOLD  = 2'd0,
    ST_DELAY = 2'd1,
    ST_RUN   = 2'd2
  } rstState_t;

  typedef struct packed {
    logic clrCnt;
    logic incCnt;
  } dlyCtl_t;

endpackage

// File: rtl/supply_rst_dp.sv
module supply_rst_dp
  import supply_rst_pkg::*;
#(
  parameter int REACT_CYCLES = 8,
  parameter int FAST_TICKS   = 16,
  parameter int SLOW_TICKS   = 32
) (
  input  logic    clk,
  input  logic    rstSync,
  input  logic    enable,
  input  logic    underVolt,
  input  logic    modeSel0,
  input  logic    modeSel1,
  input  dlyCtl_t ctl,
  output logic    uvValid,
  output logic    delayLast
);

  localparam int MAX_TICKS = (SLOW_TICKS > FAST_TICKS) ? SLOW_TICKS : FAST_TICKS;
  localparam int CNT_W     = $clog2(MAX_TICKS + 1);
  localparam int RCT_W     = $clog2(REACT_CYCLES + 1);

  logic [RCT_W-1:0] reactCnt;
  logic [CNT_W-1:0] tickCnt;
  logic [CNT_W-1:0] tickLimit;
  logic             fastMode;

  // Reaction filter: counts consecutive high samples of underVolt
  always_ff @(posedge clk) begin
    if (rstSync || !enable || !underVolt) begin
      reactCnt <= '0;
      uvValid  <= 1'b0;
    end else if (reactCnt == RCT_W'(REACT_CYCLES - 1)) begin
      uvValid  <= 1'b1;
    end else begin
      reactCnt <= reactCnt + RCT_W'(1);
    end
  end

  // Mode decode: fast only when both select bits are low
  assign fastMode  = !modeSel0 && !modeSel1;
  assign tickLimit = fastMode ? CNT_W'(FAST_TICKS) : CNT_W'(SLOW_TICKS);

  always_ff @(posedge clk) begin
    if (rstSync || !enable || ctl.clrCnt) begin
      tickCnt <= '0;
    end else if (ctl.incCnt) begin
      tickCnt <= tickCnt + CNT_W'(1);
    end
  end

  // >= keeps the delay bounded when the mode changes mid-delay
  assign delayLast = (tickCnt >= (tickLimit - CNT_W'(1)));

  // R5: a confirmed undervoltage implies the input was high on the last cycle
  a_r5_filter_follows_input: assert property (@(posedge clk) disable iff (rstSync)
    uvValid |-> $past(underVolt));

  // R8: a clear strobe from control empties the delay counter
  a_r8_restart_clears: assert property (@(posedge clk) disable iff (rstSync)
    ctl.clrCnt |=> (tickCnt == '0));

endmodule

// File: rtl/supply_rst_ctl.sv
module supply_rst_ctl
  import supply_rst_pkg::*;
(
  input  logic    clk,
  input  logic    rstSync,
  input  logic    enable,
  input  logic    tickEn,
  input  logic    wdFault,
  input  logic    uvValid,
  input  logic    delayLast,
  output dlyCtl_t ctl,
  output logic    resetN,
  output logic    releasePulse
);

  rstState_t state;

  always_comb begin
    ctl.clrCnt = (state != ST_DELAY) || uvValid || wdFault;
    ctl.incCnt = (state == ST_DELAY) && tickEn && !uvValid && !wdFault;
  end

  always_ff @(posedge clk) begin
    if (rstSync || !enable) begin
      state        <= ST_HOLD;
      releasePulse <= 1'b0;
    end else begin
      releasePulse <= 1'b0;
      if (uvValid) begin
        state <= ST_HOLD;
      end else if (wdFault) begin
        state <= ST_DELAY;
      end else begin
        case (state)
          ST_HOLD:  state <= ST_DELAY;
          ST_DELAY: begin
            if (tickEn && delayLast) begin
              state        <= ST_RUN;
              releasePulse <= 1'b1;
            end
          end
          ST_RUN:   state <= ST_RUN;
          default:  state <= ST_HOLD;
        endcase
      end
    end
  end

  assign resetN = (state == ST_RUN);

  // R7: release strobe marks the rising edge of the reset output
  a_r7_pulse_on_rise: assert property (@(posedge clk) disable iff (rstSync)
    $rose(resetN) |-> releasePulse);

  // R7: release strobe lasts a single cycle
  a_r7_pulse_single: assert property (@(posedge clk) disable iff (rstSync)
    releasePulse |=> !releasePulse);

  // R9: disabled block keeps reset asserted
  a_r9_disable_low: assert property (@(posedge clk) disable iff (rstSync)
    !enable |=> !resetN);

  // R6: watchdog fault pulls reset low on the next cycle
  a_r6_fault_low: assert property (@(posedge clk) disable iff (rstSync)
    (enable && wdFault) |=> !resetN);

  // R1: confirmed undervoltage pulls reset low on the next cycle
  a_r1_uv_low: assert property (@(posedge clk) disable iff (rstSync)
    (enable && uvValid) |=> !resetN);

endmodule

// File: rtl/supply_rst_gen.sv
module supply_rst_gen
  import supply_rst_pkg::*;
#(
  parameter int REACT_CYCLES = 8,
  parameter int FAST_TICKS   = 16,
  parameter int SLOW_TICKS   = 32
) (
  input  logic clk,
  input  logic rstSync,
  input  logic enable,
  input  logic tickEn,
  input  logic underVolt,
  input  logic wdFault,
  input  logic modeSel0,
  input  logic modeSel1,
  output logic resetN,
  output logic releasePulse
);

  dlyCtl_t ctl;
  logic    uvValid;
  logic    delayLast;

  supply_rst_dp #(
    .REACT_CYCLES(REACT_CYCLES),
    .FAST_TICKS  (FAST_TICKS),
    .SLOW_TICKS  (SLOW_TICKS)
  ) uDp (
    .clk      (clk),
    .rstSync  (rstSync),
    .enable   (enable),
    .underVolt(underVolt),
    .modeSel0 (modeSel0),
    .modeSel1 (modeSel1),
    .ctl      (ctl),
    .uvValid  (uvValid),
    .delayLast(delayLast)
  );

  supply_rst_ctl uCtl (
    .clk         (clk),
    .rstSync     (rstSync),
    .enable      (enable),
    .tickEn      (tickEn),
    .wdFault     (wdFault),
    .uvValid     (uvValid),
    .delayLast   (delayLast),
    .ctl         (ctl),
    .resetN      (resetN),
    .releasePulse(releasePulse)
  );

endmodule

// File: tb/sim_supply_rst_gen.sv
module sim_supply_rst_gen;

  localparam int REACT = 5;
  localparam int FAST  = 4;
  localparam int SLOW  = 8;

  logic clk = 1'b0;
  logic rstSync, enable, tickEn, underVolt, wdFault, modeSel0, modeSel1;
  logic resetN, releasePulse;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  supply_rst_gen #(.REACT_CYCLES(REACT), .FAST_TICKS(FAST), .SLOW_TICKS(SLOW)) u0 (
    .clk(clk), .rstSync(rstSync), .enable(enable), .tickEn(tickEn),
    .underVolt(underVolt), .wdFault(wdFault), .modeSel0(modeSel0), .modeSel1(modeSel1),
    .resetN(resetN), .releasePulse(releasePulse)
  );

  task automatic chk(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick();
    tickEn = 1'b1;
    @(negedge clk);
    tickEn = 1'b0;
    @(negedge clk);
  endtask

  function automatic int curLimit();
    return (!modeSel0 && !modeSel1) ? FAST : SLOW;
  endfunction

  // counts the delay out from zero: low before the last tick, high with strobe after it
  task automatic runDelay(input string req);
    int lim;
    lim = curLimit();
    for (int i = 0; i < lim - 1; i++) tick();
    cyc(2);
    chk(resetN, 1'b0, {req, " low before last tick"});
    chk(releasePulse, 1'b0, "R7 no strobe while low");
    tickEn = 1'b1;
    @(negedge clk);
    tickEn = 1'b0;
    chk(resetN, 1'b1, {req, " high after last tick"});
    chk(releasePulse, 1'b1, "R7 strobe with rise");
    @(negedge clk);
    chk(releasePulse, 1'b0, "R7 strobe one cycle");
    chk(resetN, 1'b1, {req, " stays high"});
  endtask

  task automatic faultPulse();
    wdFault = 1'b1;
    @(negedge clk);
    wdFault = 1'b0;
    chk(resetN, 1'b0, "R6 fault drives low next cycle");
  endtask

  initial begin
    rstSync = 1'b1; enable = 1'b1; tickEn = 1'b0; underVolt = 1'b0;
    wdFault = 1'b0; modeSel0 = 1'b0; modeSel1 = 1'b0;
    cyc(3);
    chk(resetN, 1'b0, "R9 reset state");
    chk(releasePulse, 1'b0, "R9 reset state strobe");
    for (int i = 0; i < FAST + 2; i++) tick();
    chk(resetN, 1'b0, "R9 ticks ignored under rstSync");
    rstSync = 1'b0;
    cyc(2);
    runDelay("R3 power-up fast");

    // R3/R4 sweep over all mode codes
    for (int m = 0; m < 4; m++) begin
      modeSel0 = m[0];
      modeSel1 = m[1];
      faultPulse();
      runDelay(m == 0 ? "R3 fast mode" : "R4 slow mode");
    end

    // R5 short dips, single and repeated
    underVolt = 1'b1;
    for (int i = 0; i < REACT - 1; i++) begin
      @(negedge clk);
      chk(resetN, 1'b1, "R5 short dip ignored");
    end
    underVolt = 1'b0;
    @(negedge clk);
    underVolt = 1'b1;
    cyc(REACT - 1);
    underVolt = 1'b0;
    cyc(3);
    chk(resetN, 1'b1, "R5 repeated short dips ignored");

    // R5/R1 long dip
    underVolt = 1'b1;
    cyc(REACT);
    chk(resetN, 1'b1, "R5 high until filter confirms");
    @(negedge clk);
    chk(resetN, 1'b0, "R5 low after reaction time");
    for (int i = 0; i < SLOW + 3; i++) tick();
    chk(resetN, 1'b0, "R1 held low during undervoltage");
    underVolt = 1'b0;
    cyc(2);
    runDelay("R2 delay after undervoltage");

    // R8 restart by watchdog fault
    faultPulse();
    for (int i = 0; i < SLOW - 1; i++) tick();
    faultPulse();
    runDelay("R8 restart by fault");

    // R8 restart by undervoltage
    faultPulse();
    for (int i = 0; i < SLOW - 1; i++) tick();
    underVolt = 1'b1;
    cyc(REACT + 2);
    chk(resetN, 1'b0, "R8 undervoltage during delay");
    underVolt = 1'b0;
    cyc(2);
    runDelay("R8 restart by undervoltage");

    // R9 enable low
    enable = 1'b0;
    @(negedge clk);
    chk(resetN, 1'b0, "R9 enable low forces reset");
    for (int i = 0; i < SLOW + 2; i++) tick();
    chk(resetN, 1'b0, "R9 ticks ignored while disabled");
    enable = 1'b1;
    cyc(2);
    runDelay("R9 full delay after enable");

    // R9 rstSync mid-delay clears the count
    modeSel0 = 1'b0; modeSel1 = 1'b0;
    faultPulse();
    for (int i = 0; i < FAST - 1; i++) tick();
    rstSync = 1'b1;
    @(negedge clk);
    rstSync = 1'b0;
    cyc(2);
    runDelay("R9 full delay after rstSync");

    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule